// File: doc/BRIEF.md
# Windowed Display RAM Address Generator

This block sits between a byte-wide command/data stream and the frame memory of a monochrome display controller. Each incoming byte carries a flag that says whether it is a command (flag low) or a data/parameter byte (flag high). The block decodes the commands that program a rectangular column/page window and a scan mode. It also decodes two streaming commands, one for writing and one for reading. From these it drives the address, write strobe and read strobe of an external synchronous RAM, so that successive bytes land in, or come from, successive cells of the programmed rectangle.

The rectangle can be walked column-first or page-first. It can be walked forward from its origin or backward from its far corner. Either axis can be mirrored when it is turned into a physical address. Reads first return a dummy byte. After that each cell is presented for two read requests before the pointer moves. Parameter bytes are gathered by a small sequencer that knows how many bytes each opcode takes. A command byte always ends any write or read stream.

Top module: `disp_ram_walker`

## Requirements
- R1: After reset the column window and page window are both 0..0, all scan-mode bits are 0, the block is idle, and `ram_we`, `ram_re`, `rd_valid` and `ram_addr` are 0.
- R2: Command 0x15 takes two parameter bytes, the first column then the last column. Command 0x75 takes two parameter bytes, the first page then the last page. A column value above COL_MAX (32) is saturated to COL_MAX, and a page value above PAGE_MAX (129) is saturated to PAGE_MAX.
- R3: Command 0x5C starts a write stream. Every following flag-high byte produces exactly one `ram_we` cycle, one clock after the byte is sampled, with `ram_wdata` equal to the byte and `ram_addr` equal to the current cell.
- R4: The physical address of a cell is page*(COL_MAX+1)+column. In the default column-first order the column steps from its first to its last value, then reloads its first value while the page steps. After the last cell of the window the walk returns to the window origin.
- R5: Command 0xBC takes three parameter bytes. Only the first is used. Its bit 0 mirrors the page (physical page = PAGE_MAX-page) and its bit 1 mirrors the column (physical column = COL_MAX-column).
- R6: Bit 2 of the scan byte selects page-first order: the page is the fast axis, and the column steps when the page wraps.
- R7: Bit 3 of the scan byte selects a reversed walk. The origin is the (last column, last page) corner and both axes count down, reloading their last value after passing their first.
- R8: When a first value exceeds the last value on an axis, that axis holds the single cell at the first value.
- R9: Command 0x5D starts a read stream. The first `rd_req` returns 0x00 without a RAM access. Each later request reads the current cell. Each cell is returned for two consecutive requests, and the pointer advances after the second. `rd_valid` rises two clocks after the request is sampled.
- R10: A flag-low byte ends any write or read stream. Flag-high bytes outside a write stream never write RAM. `rd_req` outside a read stream produces no `rd_valid`. Opcodes other than 0x15, 0x75, 0xBC, 0x5C and 0x5D take no parameters and change nothing.
- R11: Completing a window or scan command, or issuing 0x5C or 0x5D, returns the pointer to the window origin. Issuing 0x5D also restores the leading dummy byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is present this cycle |
| in_dc | input | 1 | 1 = data/parameter byte, 0 = command byte |
| in_byte | input | 8 | Incoming command or data byte |
| rd_req | input | 1 | Request the next read-stream byte |
| rd_valid | output | 1 | `rd_byte` holds a returned byte |
| rd_byte | output | 8 | Returned read byte (0x00 for the dummy) |
| ram_addr | output | AW (13) | RAM cell address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read strobe; data is expected on `ram_rdata` one clock later |
| ram_rdata | input | 8 | RAM read data |

## Verification
Several properties are checked on every cycle: each axis pointer stays inside its clamped window; on wrap an axis reloads its origin value; a non-wrapping step moves by exactly one in the selected direction; the saturated window registers never exceed their limits. The same checks confirm that a write strobe only follows a data byte, that the two RAM strobes never coincide, and that a returned byte either follows a RAM read or is the dummy. The bench is needed to show the parts these per-cycle checks cannot see. That covers the complete address order under each scan mode, mirroring, saturation and clamping. It also covers the pairing of read bytes after the dummy, the reload on new commands, and the absence of strobes after ignored stimulus.

// File: rtl/walker_pkg.sv
package walker_pkg;

   localparam logic [7:0] OP_COLWIN  = 8'h15;
   localparam logic [7:0] OP_PAGEWIN = 8'h75;
   localparam logic [7:0] OP_SCAN    = 8'hBC;
   localparam logic [7:0] OP_WRITE   = 8'h5C;
   localparam logic [7:0] OP_READ    = 8'h5D;

   typedef enum logic [1:0] {
      M_IDLE  = 2'd0,
      M_PARAM = 2'd1,
      M_WRITE = 2'd2,
      M_READ  = 2'd3
   } mode_e;

   // bit3 reversed walk, bit2 page-first, bit1 mirror column, bit0 mirror page
   typedef struct packed {
      logic inv_walk;
      logic page_first;
      logic mir_col;
      logic mir_page;
   } scan_t;

   function automatic logic [1:0] param_count(input logic [7:0] op);
      case (op)
         OP_COLWIN, OP_PAGEWIN: return 2'd2;
         OP_SCAN:               return 2'd3;
         default:               return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/walker_cmd.sv
module walker_cmd
   import walker_pkg::*;
#(
   parameter int COL_MAX  = 32,
   parameter int PAGE_MAX = 129,
   parameter int CW       = 6,
   parameter int PW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_dc,
   input  logic [7:0]    in_byte,
   output logic [CW-1:0] col_lo,
   output logic [CW-1:0] col_hi,
   output logic [PW-1:0] pg_lo,
   output logic [PW-1:0] pg_hi,
   output scan_t         scan,
   output mode_e         mode,
   output logic          load,
   output logic          wr_fire
);

   mode_e         mode_q;
   logic [7:0]    op_q;
   logic [1:0]    idx_q;
   logic [7:0]    stage_q;
   logic [CW-1:0] col_lo_q, col_hi_q;
   logic [PW-1:0] pg_lo_q, pg_hi_q;
   scan_t         scan_q;
   logic          load_q;
   logic          is_cmd, is_dat, last_param;

   function automatic logic [CW-1:0] sat_col(input logic [7:0] b);
      if (int'(b) > COL_MAX) return CW'(COL_MAX);
      return CW'(b);
   endfunction

   function automatic logic [PW-1:0] sat_page(input logic [7:0] b);
      if (int'(b) > PAGE_MAX) return PW'(PAGE_MAX);
      return PW'(b);
   endfunction

   always_comb begin
      is_cmd     = in_valid & ~in_dc;
      is_dat     = in_valid & in_dc;
      last_param = (idx_q == (param_count(op_q) - 2'd1));
      wr_fire    = is_dat & (mode_q == M_WRITE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= M_IDLE;
         op_q     <= 8'h00;
         idx_q    <= 2'd0;
         stage_q  <= 8'h00;
         col_lo_q <= '0;
         col_hi_q <= '0;
         pg_lo_q  <= '0;
         pg_hi_q  <= '0;
         scan_q   <= '0;
         load_q   <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (is_cmd) begin
            op_q  <= in_byte;
            idx_q <= 2'd0;
            if (param_count(in_byte) != 2'd0) begin
               mode_q <= M_PARAM;
            end else if (in_byte == OP_WRITE) begin
               mode_q <= M_WRITE;
               load_q <= 1'b1;
            end else if (in_byte == OP_READ) begin
               mode_q <= M_READ;
               load_q <= 1'b1;
            end else begin
               mode_q <= M_IDLE;
            end
         end else if (is_dat && mode_q == M_PARAM) begin
            if (idx_q == 2'd0) stage_q <= in_byte;
            if (last_param) begin
               case (op_q)
                  OP_COLWIN: begin
                     col_lo_q <= sat_col(stage_q);
                     col_hi_q <= sat_col(in_byte);
                  end
                  OP_PAGEWIN: begin
                     pg_lo_q <= sat_page(stage_q);
                     pg_hi_q <= sat_page(in_byte);
                  end
                  OP_SCAN:  scan_q <= scan_t'(stage_q[3:0]);
                  default:  ;
               endcase
               mode_q <= M_IDLE;
               load_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 2'd1;
            end
         end
      end
   end

   assign col_lo = col_lo_q;
   assign col_hi = col_hi_q;
   assign pg_lo  = pg_lo_q;
   assign pg_hi  = pg_hi_q;
   assign scan   = scan_q;
   assign mode   = mode_q;
   assign load   = load_q;

   // R2: saturated window registers stay within the legal ranges
   a_r2_col_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(col_lo_q) <= COL_MAX) && (int'(col_hi_q) <= COL_MAX));
   a_r2_page_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(pg_lo_q) <= PAGE_MAX) && (int'(pg_hi_q) <= PAGE_MAX));
   // R11: a reload pulse only follows a byte that was sampled
   a_r11_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
      load_q |-> $past(in_valid));

endmodule

// File: rtl/walker_axis.sv
module walker_axis #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic         inv,
   input  logic         load,
   input  logic         step,
   output logic [W-1:0] cur,
   output logic         at_last
);

   logic [W-1:0] pos_q, hi_eff, first, lastv, nxt;

   always_comb begin
      hi_eff  = (hi < lo) ? lo : hi;
      first   = inv ? hi_eff : lo;
      lastv   = inv ? lo : hi_eff;
      cur     = load ? first : pos_q;
      at_last = (cur == lastv);
      if (at_last)  nxt = first;
      else if (inv) nxt = cur - W'(1);
      else          nxt = cur + W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= step ? nxt : cur;
   end

   // R8: the pointer never leaves the clamped window
   a_r8_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (cur >= lo) && (cur <= hi_eff));
   // R4: stepping off the last value returns to the origin value
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_last) |=> (load || cur == $past(first)));
   // R7: an inner step moves by one in the selected direction
   a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !at_last) |=>
         (load || cur == ($past(inv) ? $past(cur) - W'(1) : $past(cur) + W'(1))));

endmodule

// File: rtl/walker_map.sv
module walker_map #(
   parameter int COL_MAX  = 32,
   parameter int PAGE_MAX = 129,
   parameter int CW       = 6,
   parameter int PW       = 8,
   parameter int AW       = 13
) (
   input  logic [CW-1:0] col,
   input  logic [PW-1:0] pg,
   input  logic          mir_col,
   input  logic          mir_page,
   output logic [AW-1:0] addr
);

   localparam int NCOL  = COL_MAX + 1;
   localparam int NPAGE = PAGE_MAX + 1;

   logic [CW-1:0] pc;
   logic [PW-1:0] pp;

   always_comb begin
      pc = mir_col  ? (CW'(COL_MAX)  - col) : col;
      pp = mir_page ? (PW'(PAGE_MAX) - pg)  : pg;
   end

   generate
      if ((NCOL & (NCOL - 1)) == 0) begin : g_pow2
         // row pitch is a power of two: concatenate instead of multiplying
         assign addr = AW'({pp, pc});
      end else begin : g_mult
         assign addr = AW'(pp) * AW'(NCOL) + AW'(pc);
      end
   endgenerate

   // R4: every produced address lies inside the frame memory
   always_comb begin
      a_r4_addr_range: assert (int'(addr) < NCOL * NPAGE);
   end

endmodule

// File: rtl/disp_ram_walker.sv
module disp_ram_walker
   import walker_pkg::*;
#(
   parameter int COL_MAX  = 32,
   parameter int PAGE_MAX = 129,
   localparam int CW      = $clog2(COL_MAX + 1),
   localparam int PW      = $clog2(PAGE_MAX + 1),
   localparam int AW      = $clog2((COL_MAX + 1) * (PAGE_MAX + 1))
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_dc,
   input  logic [7:0]    in_byte,
   input  logic          rd_req,
   output logic          rd_valid,
   output logic [7:0]    rd_byte,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [7:0]    ram_wdata,
   output logic          ram_re,
   input  logic [7:0]    ram_rdata
);

   generate
      if (COL_MAX < 1 || COL_MAX > 255) begin : g_bad_col
         $error("COL_MAX must lie in 1..255");
      end
      if (PAGE_MAX < 1 || PAGE_MAX > 255) begin : g_bad_page
         $error("PAGE_MAX must lie in 1..255");
      end
   endgenerate

   logic [CW-1:0] col_lo, col_hi, col_cur;
   logic [PW-1:0] pg_lo, pg_hi, pg_cur;
   scan_t         scan;
   mode_e         mode;
   logic          load, wr_fire;
   logic          col_last, pg_last, col_step, pg_step;
   logic [AW-1:0] map_addr;

   walker_cmd #(.COL_MAX(COL_MAX), .PAGE_MAX(PAGE_MAX), .CW(CW), .PW(PW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dc(in_dc), .in_byte(in_byte),
      .col_lo(col_lo), .col_hi(col_hi), .pg_lo(pg_lo), .pg_hi(pg_hi),
      .scan(scan), .mode(mode), .load(load), .wr_fire(wr_fire)
   );

   // read-stream sequencing
   logic dummy_q, half_q, dummy_eff, half_eff;
   logic rd_ok, adv;
   logic rv1_q, rdum1_q, rd_valid_q, rdum2_q;
   logic ram_we_q, ram_re_q;
   logic [7:0] wdata_q;
   logic [AW-1:0] addr_q;

   always_comb begin
      dummy_eff = load ? 1'b1 : dummy_q;
      half_eff  = load ? 1'b0 : half_q;
      rd_ok     = rd_req & (mode == M_READ) & ~(in_valid & ~in_dc);
      adv       = wr_fire | (rd_ok & ~dummy_eff & half_eff);
      if (scan.page_first) begin
         pg_step  = adv;
         col_step = adv & pg_last;
      end else begin
         col_step = adv;
         pg_step  = adv & col_last;
      end
   end

   walker_axis #(.W(CW)) u_col (
      .clk(clk), .rst_n(rst_n), .lo(col_lo), .hi(col_hi), .inv(scan.inv_walk),
      .load(load), .step(col_step), .cur(col_cur), .at_last(col_last)
   );

   walker_axis #(.W(PW)) u_page (
      .clk(clk), .rst_n(rst_n), .lo(pg_lo), .hi(pg_hi), .inv(scan.inv_walk),
      .load(load), .step(pg_step), .cur(pg_cur), .at_last(pg_last)
   );

   walker_map #(.COL_MAX(COL_MAX), .PAGE_MAX(PAGE_MAX), .CW(CW), .PW(PW), .AW(AW)) u_map (
      .col(col_cur), .pg(pg_cur), .mir_col(scan.mir_col), .mir_page(scan.mir_page),
      .addr(map_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_we_q   <= 1'b0;
         ram_re_q   <= 1'b0;
         wdata_q    <= 8'h00;
         addr_q     <= '0;
         dummy_q    <= 1'b1;
         half_q     <= 1'b0;
         rv1_q      <= 1'b0;
         rdum1_q    <= 1'b0;
         rd_valid_q <= 1'b0;
         rdum2_q    <= 1'b0;
      end else begin
         ram_we_q <= wr_fire;
         if (wr_fire)         wdata_q <= in_byte;
         if (wr_fire | rd_ok) addr_q  <= map_addr;
         ram_re_q   <= rd_ok & ~dummy_eff;
         rv1_q      <= rd_ok;
         rdum1_q    <= rd_ok & dummy_eff;
         rd_valid_q <= rv1_q;
         rdum2_q    <= rdum1_q;
         dummy_q    <= rd_ok ? 1'b0 : dummy_eff;
         half_q     <= (rd_ok & ~dummy_eff) ? ~half_eff : half_eff;
      end
   end

   assign ram_we    = ram_we_q;
   assign ram_re    = ram_re_q;
   assign ram_wdata = wdata_q;
   assign ram_addr  = addr_q;
   assign rd_valid  = rd_valid_q;
   assign rd_byte   = rdum2_q ? 8'h00 : ram_rdata;

   // R3: a write strobe only follows a sampled data byte
   a_r3_we_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(in_valid && in_dc));
   // R10: RAM write and RAM read never overlap
   a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));
   // R9: a real read byte is preceded by a RAM read
   a_r9_real_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rdum2_q) |-> $past(ram_re));
   // R9: the dummy byte costs no RAM access
   a_r9_dummy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rdum2_q) |-> !$past(ram_re));

endmodule

// File: tb/sim_disp_ram_walker.sv
module sim_disp_ram_walker;

   localparam int CMAX  = 32;
   localparam int PMAX  = 129;
   localparam int NCOL  = CMAX + 1;
   localparam int NCELL = NCOL * (PMAX + 1);
   localparam int AW    = $clog2(NCELL);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_dc = 1'b0, rd_req = 1'b0;
   logic [7:0]    in_byte = 8'h00;
   logic          rd_valid, ram_we, ram_re;
   logic [7:0]    rd_byte, ram_wdata;
   logic [7:0]    ram_rdata = 8'h00;
   logic [AW-1:0] ram_addr;

   int errors = 0;
   int checks = 0;
   int we_cnt = 0;
   int rv_cnt = 0;

   always #10 clk = ~clk;

   disp_ram_walker u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dc(in_dc), .in_byte(in_byte),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_re(ram_re), .ram_rdata(ram_rdata)
   );

   // external RAM and its shadow copy
   logic [7:0] ram [NCELL];
   logic [7:0] sh  [NCELL];

   always @(posedge clk) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= ram[ram_addr];
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard queues
   logic [AW+7:0] wq[$];
   string         wtag[$];
   logic [7:0]    rq[$];
   string         rtag[$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_we) begin
            we_cnt++;
            if (wq.size() == 0) check(1'b0, "R10 unexpected write", int'(ram_addr), -1);
            else begin
               logic [AW+7:0] e;
               string t;
               e = wq.pop_front();
               t = wtag.pop_front();
               check({ram_addr, ram_wdata} == e, t, int'({ram_addr, ram_wdata}), int'(e));
            end
         end
         if (rd_valid) begin
            rv_cnt++;
            if (rq.size() == 0) check(1'b0, "R10 unexpected read byte", int'(rd_byte), -1);
            else begin
               logic [7:0] e;
               string t;
               e = rq.pop_front();
               t = rtag.pop_front();
               check(rd_byte == e, t, int'(rd_byte), int'(e));
            end
         end
      end
   end

   // independent reference model of the walk
   int  m_clo = 0, m_chi = 0, m_plo = 0, m_phi = 0;
   bit  [3:0] m_scan = 4'h0;
   int  m_c = 0, m_p = 0;
   bit  m_dummy = 1'b1, m_half = 1'b0;

   function automatic int sat(input int v, input int mx);
      return (v > mx) ? mx : v;
   endfunction
   function automatic int top_of(input int lo, input int hi);
      return (hi < lo) ? lo : hi;
   endfunction
   function automatic int m_first(input int lo, input int hi);
      return m_scan[3] ? top_of(lo, hi) : lo;
   endfunction
   function automatic int m_lastv(input int lo, input int hi);
      return m_scan[3] ? lo : top_of(lo, hi);
   endfunction
   function automatic int m_addr();
      int pc, pp;
      pc = m_scan[1] ? CMAX - m_c : m_c;
      pp = m_scan[0] ? PMAX - m_p : m_p;
      return pp * NCOL + pc;
   endfunction

   task automatic m_origin();
      m_c = m_first(m_clo, m_chi);
      m_p = m_first(m_plo, m_phi);
      m_dummy = 1'b1;
      m_half  = 1'b0;
   endtask

   task automatic m_step();
      int d;
      d = m_scan[3] ? -1 : 1;
      if (!m_scan[2]) begin
         if (m_c == m_lastv(m_clo, m_chi)) begin
            m_c = m_first(m_clo, m_chi);
            if (m_p == m_lastv(m_plo, m_phi)) m_p = m_first(m_plo, m_phi);
            else m_p = m_p + d;
         end else m_c = m_c + d;
      end else begin
         if (m_p == m_lastv(m_plo, m_phi)) begin
            m_p = m_first(m_plo, m_phi);
            if (m_c == m_lastv(m_clo, m_chi)) m_c = m_first(m_clo, m_chi);
            else m_c = m_c + d;
         end else m_p = m_p + d;
      end
   endtask

   // drivers
   task automatic send(input bit dc, input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1; in_dc = dc; in_byte = b;
      @(negedge clk);
      in_valid = 1'b0; in_dc = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] b);
      send(1'b0, b);
      if (b == 8'h5C || b == 8'h5D) m_origin();
   endtask

   task automatic set_cols(input int a, input int b);
      send(1'b0, 8'h15); send(1'b1, a[7:0]); send(1'b1, b[7:0]);
      m_clo = sat(a, CMAX); m_chi = sat(b, CMAX); m_origin();
   endtask

   task automatic set_pages(input int a, input int b);
      send(1'b0, 8'h75); send(1'b1, a[7:0]); send(1'b1, b[7:0]);
      m_plo = sat(a, PMAX); m_phi = sat(b, PMAX); m_origin();
   endtask

   task automatic set_scan(input logic [7:0] v);
      send(1'b0, 8'hBC); send(1'b1, v); send(1'b1, 8'hFF); send(1'b1, 8'hFF);
      m_scan = v[3:0]; m_origin();
   endtask

   task automatic wr(input logic [7:0] b, input string tag);
      int a;
      a = m_addr();
      wq.push_back({a[AW-1:0], b});
      wtag.push_back(tag);
      sh[a] = b;
      m_step();
      send(1'b1, b);
   endtask

   task automatic rdq(input string tag);
      if (m_dummy) begin
         rq.push_back(8'h00);
         m_dummy = 1'b0;
      end else begin
         rq.push_back(sh[m_addr()]);
         if (m_half) m_step();
         m_half = !m_half;
      end
      rtag.push_back(tag);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int w0, r0;
      for (int i = 0; i < NCELL; i++) begin
         ram[i] = 8'(i) ^ 8'hA5;
         sh[i]  = 8'(i) ^ 8'hA5;
      end
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check(ram_we == 1'b0,  "R1 ram_we after reset",   int'(ram_we), 0);
      check(ram_re == 1'b0,  "R1 ram_re after reset",   int'(ram_re), 0);
      check(rd_valid == 1'b0,"R1 rd_valid after reset", int'(rd_valid), 0);
      check(ram_addr == '0,  "R1 ram_addr after reset", int'(ram_addr), 0);
      // R1: default 0..0 window, writes all land at cell 0
      cmd(8'h5C);
      wr(8'h11, "R1 default window cell 0");
      wr(8'h12, "R1 default window cell 0 again");

      // R2 R3 R4: 3x2 window, column-first, wrap to origin
      set_cols(2, 4);
      set_pages(1, 2);
      cmd(8'h5C);
      for (int i = 0; i < 7; i++) wr(8'h20 + 8'(i), "R4 column-first walk");

      // R2 R8: saturation and single-cell clamp
      set_cols(40, 50);
      set_pages(200, 3);
      cmd(8'h5C);
      wr(8'h31, "R2 saturated last cell");
      wr(8'h32, "R8 clamped single cell");

      // R5: mirrored axes
      set_cols(0, 1);
      set_pages(0, 1);
      set_scan(8'h03);
      cmd(8'h5C);
      for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i), "R5 mirrored walk");

      // R6: page-first order
      set_scan(8'h04);
      set_cols(1, 2);
      set_pages(5, 6);
      cmd(8'h5C);
      for (int i = 0; i < 5; i++) wr(8'h50 + 8'(i), "R6 page-first walk");

      // R7: reversed walk
      set_scan(8'h08);
      set_cols(1, 2);
      set_pages(3, 4);
      cmd(8'h5C);
      for (int i = 0; i < 5; i++) wr(8'h60 + 8'(i), "R7 reversed walk");

      // R9: read stream with dummy and two bytes per cell
      set_scan(8'h00);
      set_cols(2, 4);
      set_pages(1, 2);
      cmd(8'h5D);
      rdq("R9 dummy byte");
      @(negedge clk);
      check(rd_valid == 1'b1, "R9 rd_valid two clocks after request", int'(rd_valid), 1);
      for (int i = 0; i < 8; i++) rdq("R9 paired read");
      // R11: reissuing the read command restarts at origin with a dummy
      cmd(8'h5D);
      rdq("R11 dummy after restart");
      rdq("R11 origin after restart");
      idle(4);

      // R10: ignored stimulus produces no strobes
      w0 = we_cnt;
      r0 = rv_cnt;
      cmd(8'h5C);
      wr(8'h71, "R10 write before ending command");
      cmd(8'h00);
      send(1'b1, 8'h72);
      send(1'b1, 8'h73);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      cmd(8'hA6);
      send(1'b1, 8'h74);
      idle(4);
      check(we_cnt - w0 == 1, "R10 writes after command ended stream", we_cnt - w0, 1);
      check(rv_cnt == r0, "R10 read bytes outside read stream", rv_cnt - r0, 0);
      // R11: unknown opcode kept the window; new write stream restarts at origin
      cmd(8'h5C);
      wr(8'h75, "R11 write restarts at origin");
      idle(4);

      check(wq.size() == 0, "R3 pending expected writes", wq.size(), 0);
      check(rq.size() == 0, "R9 pending expected reads", rq.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule